// File: doc/BRIEF.md
# Load/Store Byte-Lane Alignment Unit

This block sits between a core's load/store stage and a data memory organised as 32-bit words. It forms the effective address by adding a sign-extended 12-bit displacement to a base register value. It then splits that address into a word-aligned memory address and a two-bit lane index. A single three-bit access code gives the access size (byte, halfword or word) and, for loads, whether a narrow result is zero-extended or sign-extended.

On the store side the unit produces per-byte write strobes and a write word in which the source bytes are copied onto the lanes the strobes enable. On the load side it takes the word returned by memory, selects the addressed byte or halfword, and extends it to 32 bits. The same strobes also mark the lanes a load reads. Accesses that cross their natural boundary raise a misalignment flag. Codes that name no access raise an illegal flag. Both flags silence the strobes and the load result. The unit is purely combinational and adds no cycle to the access path.

Top module: `lsu_lane_align`

## Requirements
- R1: `mem_addr` equals `base_addr` plus `offset` sign-extended from bit 11, with bits [1:0] forced to zero. The lane index is bits [1:0] of that sum.
- R2: For a legal, aligned access, `byte_en` is 4'b0001 shifted left by the lane for codes 0 and 4. It is 4'b0011 shifted left by lane[1]*2 for codes 1 and 5, and 4'b1111 for code 2. Bit n of `byte_en` is memory byte lane n (data bits 8n+7..8n). This holds for both loads and stores.
- R3: For a legal store, `mem_wdata` repeats `store_data[7:0]` on all four lanes for code 0. It repeats `store_data[15:0]` in both halves for code 1, and equals `store_data` for code 2. This holds whether or not the access is aligned.
- R4: A load with code 0 returns the byte on the addressed lane, sign-extended from its bit 7.
- R5: A load with code 1 returns the halfword starting at the addressed lane, sign-extended from its bit 15.
- R6: A load with code 4 or 5 returns the addressed byte or halfword zero-extended to 32 bits.
- R7: A load with code 2 returns `mem_rdata` unchanged.
- R8: A halfword access (code 1 or 5) with lane bit 0 set, or a word access with a nonzero lane, sets `misaligned`. It also drives `byte_en` and `load_result` to zero.
- R9: Codes 3, 6 and 7, and codes 4 and 5 on a store, set `illegal`. They also force `misaligned`, `byte_en` and `load_result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_is_store | input | 1 | 1 for a store, 0 for a load |
| size_code | input | 3 | Access code: 0 byte, 1 half, 2 word, 4 unsigned byte, 5 unsigned half |
| base_addr | input | ADDR_W (32) | Base register value |
| offset | input | OFF_W (12) | Signed displacement |
| store_data | input | 32 | Register value to store, right-aligned |
| mem_rdata | input | 32 | Word returned by memory for a load |
| mem_addr | output | ADDR_W (32) | Word-aligned memory address |
| byte_en | output | 4 | Per-lane strobes |
| mem_wdata | output | 32 | Store word with bytes placed on lanes |
| load_result | output | 32 | Extended load value |
| misaligned | output | 1 | Access crosses its natural boundary |
| illegal | output | 1 | Access code is undefined for this direction |

## Verification
Every code runs with every lane for both loads and stores, which separates the strobe shapes, the halfword lane rule and the word alignment rule. The memory word puts a distinct value with a different top bit on each lane (0x80FF7F01-style patterns). A wrong lane pick or a sign fill in place of a zero fill therefore gives a different result. Negative displacements and base values near a word edge show whether the adder sign-extends and carries into the word address. A long run with random operands then covers the remaining combinations of codes, lanes and data.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int DATA_W = 32;
  localparam int LANES  = DATA_W / 8;
  localparam int LANE_W = $clog2(LANES);

  typedef enum logic [1:0] {
    ACC_BYTE = 2'd0,
    ACC_HALF = 2'd1,
    ACC_WORD = 2'd2
  } acc_size_e;
endpackage

// File: rtl/lsu_addr_gen.sv
module lsu_addr_gen
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  offset,
  output logic [ADDR_W-1:0] word_addr,
  output logic [LANE_W-1:0] lane
);
  localparam int EXT_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] off_ext;
  logic [ADDR_W-1:0] eff_addr;

  always_comb begin
    off_ext   = {{EXT_W{offset[OFF_W-1]}}, offset};
    eff_addr  = base_addr + off_ext;
    word_addr = {eff_addr[ADDR_W-1:LANE_W], {LANE_W{1'b0}}};
    lane      = eff_addr[LANE_W-1:0];
  end
endmodule

// File: rtl/lsu_width_decode.sv
module lsu_width_decode
  import lsu_pkg::*;
(
  input  logic [2:0]        size_code,
  input  logic              op_is_store,
  input  logic [LANE_W-1:0] lane,
  output acc_size_e         acc_size,
  output logic              zero_ext,
  output logic              illegal,
  output logic              misaligned
);
  logic code_bad;

  always_comb begin
    acc_size = ACC_BYTE;
    zero_ext = 1'b0;
    code_bad = 1'b0;
    case (size_code)
      3'd0: acc_size = ACC_BYTE;
      3'd1: acc_size = ACC_HALF;
      3'd2: acc_size = ACC_WORD;
      3'd4: begin acc_size = ACC_BYTE; zero_ext = 1'b1; end
      3'd5: begin acc_size = ACC_HALF; zero_ext = 1'b1; end
      default: code_bad = 1'b1;
    endcase
    // unsigned variants name no store
    illegal = code_bad | (op_is_store & size_code[2]);

    misaligned = 1'b0;
    if (!illegal) begin
      if (acc_size == ACC_HALF) misaligned = lane[0];
      else if (acc_size == ACC_WORD) misaligned = |lane;
    end
  end
endmodule

// File: rtl/lsu_store_lane.sv
module lsu_store_lane
  import lsu_pkg::*;
(
  input  acc_size_e         acc_size,
  input  logic [LANE_W-1:0] lane,
  input  logic              access_ok,
  input  logic [DATA_W-1:0] store_data,
  output logic [LANES-1:0]  byte_en,
  output logic [DATA_W-1:0] mem_wdata
);
  logic [LANES-1:0] shape;

  always_comb begin
    case (acc_size)
      ACC_BYTE: shape = {{(LANES-1){1'b0}}, 1'b1} << lane;
      ACC_HALF: shape = {{(LANES-2){1'b0}}, 2'b11} << {lane[LANE_W-1:1], 1'b0};
      default:  shape = {LANES{1'b1}};
    endcase
    byte_en = access_ok ? shape : '0;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign mem_wdata[8*i +: 8] =
      (acc_size == ACC_BYTE) ? store_data[7:0] :
      (acc_size == ACC_HALF) ? store_data[8*(i%2) +: 8] :
                               store_data[8*i +: 8];
  end
endmodule

// File: rtl/lsu_load_extract.sv
module lsu_load_extract
  import lsu_pkg::*;
(
  input  acc_size_e         acc_size,
  input  logic [LANE_W-1:0] lane,
  input  logic              zero_ext,
  input  logic              access_ok,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] load_result
);
  logic [DATA_W-1:0] shifted;
  logic [7:0]        sel_b;
  logic [15:0]       sel_h;
  logic              fill;

  always_comb begin
    shifted = mem_rdata >> {lane, 3'b000};
    sel_b   = shifted[7:0];
    sel_h   = shifted[15:0];
    case (acc_size)
      ACC_BYTE: begin
        fill        = ~zero_ext & sel_b[7];
        load_result = {{(DATA_W-8){fill}}, sel_b};
      end
      ACC_HALF: begin
        fill        = ~zero_ext & sel_h[15];
        load_result = {{(DATA_W-16){fill}}, sel_h};
      end
      default: begin
        fill        = 1'b0;
        load_result = mem_rdata;
      end
    endcase
    if (!access_ok) load_result = '0;
  end
endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic              op_is_store,
  input  logic [2:0]        size_code,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [OFF_W-1:0]  offset,
  input  logic [31:0]       store_data,
  input  logic [31:0]       mem_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        byte_en,
  output logic [31:0]       mem_wdata,
  output logic [31:0]       load_result,
  output logic              misaligned,
  output logic              illegal
);
  logic [LANE_W-1:0] lane;
  acc_size_e         acc_size;
  logic              zero_ext;
  logic              access_ok;

  lsu_addr_gen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_addr (
    .base_addr (base_addr),
    .offset    (offset),
    .word_addr (mem_addr),
    .lane      (lane)
  );

  lsu_width_decode u_dec (
    .size_code   (size_code),
    .op_is_store (op_is_store),
    .lane        (lane),
    .acc_size    (acc_size),
    .zero_ext    (zero_ext),
    .illegal     (illegal),
    .misaligned  (misaligned)
  );

  assign access_ok = ~illegal & ~misaligned;

  lsu_store_lane u_st (
    .acc_size   (acc_size),
    .lane       (lane),
    .access_ok  (access_ok),
    .store_data (store_data),
    .byte_en    (byte_en),
    .mem_wdata  (mem_wdata)
  );

  lsu_load_extract u_ld (
    .acc_size    (acc_size),
    .lane        (lane),
    .zero_ext    (zero_ext),
    .access_ok   (access_ok),
    .mem_rdata   (mem_rdata),
    .load_result (load_result)
  );
endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk #(
  parameter int ADDR_W = 32
) (
  input logic              op_is_store,
  input logic [2:0]        size_code,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        byte_en,
  input logic [31:0]       load_result,
  input logic              misaligned,
  input logic              illegal
);
  always_comb begin
    a_r1_word_aligned: assert (mem_addr[1:0] == 2'b00)
      else $error("R1 address not word aligned");
    a_r2_strobe_count: assert ($countones(byte_en) inside {0, 1, 2, 4})
      else $error("R2 strobe count invalid");
    a_r2_word_full: assert (!(size_code == 3'd2 && !misaligned) || byte_en == 4'b1111)
      else $error("R2 aligned word strobes incomplete");
    a_r6_zero_fill: assert (!(!op_is_store && size_code == 3'd4) || load_result[31:8] == 24'd0)
      else $error("R6 unsigned byte has upper bits");
    a_r8_misaligned_quiet: assert (!misaligned || (byte_en == 4'b0000 && load_result == 32'd0))
      else $error("R8 misaligned access not silenced");
    a_r9_illegal_quiet: assert (!illegal || (byte_en == 4'b0000 && !misaligned && load_result == 32'd0))
      else $error("R9 illegal access not silenced");
  end
endmodule

bind lsu_lane_align lsu_lane_align_chk #(.ADDR_W(ADDR_W)) u_chk (
  .op_is_store (op_is_store),
  .size_code   (size_code),
  .mem_addr    (mem_addr),
  .byte_en     (byte_en),
  .load_result (load_result),
  .misaligned  (misaligned),
  .illegal     (illegal)
);

// File: tb/lsu_lane_align_tb.sv
module lsu_lane_align_tb;
  logic clk;
  logic rst_n;
  int   n_tests;
  int   n_fail;

  logic        op_is_store;
  logic [2:0]  size_code;
  logic [31:0] base_addr;
  logic [11:0] offset;
  logic [31:0] store_data;
  logic [31:0] mem_rdata;
  logic [31:0] mem_addr;
  logic [3:0]  byte_en;
  logic [31:0] mem_wdata;
  logic [31:0] load_result;
  logic        misaligned;
  logic        illegal;

  lsu_lane_align u_dut (
    .op_is_store (op_is_store),
    .size_code   (size_code),
    .base_addr   (base_addr),
    .offset      (offset),
    .store_data  (store_data),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .byte_en     (byte_en),
    .mem_wdata   (mem_wdata),
    .load_result (load_result),
    .misaligned  (misaligned),
    .illegal     (illegal)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(string tag, longint act, longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h (st=%0d code=%0d base=%h off=%h)",
               tag, act, exp, op_is_store, size_code, base_addr, offset);
    end
  endtask

  // behavioural reference, compared once per clock
  task automatic run_one(bit st, int code, logic [31:0] b, logic [11:0] o,
                         logic [31:0] sd, logic [31:0] rd);
    longint ea, e_addr, e_wd, e_ld, v;
    int lane, nbytes, e_be;
    bit e_ill, e_mis, ok;
    string ld_tag;
    @(posedge clk);
    #1;
    op_is_store = st; size_code = code[2:0]; base_addr = b; offset = o;
    store_data = sd; mem_rdata = rd;
    ea = (longint'(b) + ((o >= 12'h800) ? longint'(o) - 4096 : longint'(o))) & 64'hFFFF_FFFF;
    e_addr = ea & 64'hFFFF_FFFC;
    lane   = int'(ea % 4);
    e_ill  = (code == 3) || (code > 5) || (st && code >= 4);
    nbytes = 1 << (code % 4);
    e_mis  = !e_ill && ((nbytes == 2 && lane % 2 == 1) || (nbytes == 4 && lane != 0));
    ok     = !e_ill && !e_mis;
    e_be   = ok ? (((1 << nbytes) - 1) << lane) : 0;
    e_wd = 0;
    for (int i = 0; i < 4; i++) begin
      int src;
      src = (nbytes == 4) ? i : (i % nbytes);
      e_wd = e_wd | (((longint'(sd) >> (8*src)) & 255) << (8*i));
    end
    v = (longint'(rd) >> (8*lane)) & ((longint'(1) << (8*nbytes)) - 1);
    if (code < 4 && nbytes < 4 && v >= (longint'(1) << (8*nbytes - 1)))
      v = v + 64'hFFFF_FFFF - ((longint'(1) << (8*nbytes)) - 1);
    e_ld = ok ? v : 0;
    if (e_ill) ld_tag = "R9";
    else if (e_mis) ld_tag = "R8";
    else if (code == 0) ld_tag = "R4";
    else if (code == 1) ld_tag = "R5";
    else if (code == 2) ld_tag = "R7";
    else ld_tag = "R6";
    @(negedge clk);
    check("R1 mem_addr", mem_addr, e_addr);
    check(e_ill ? "R9 byte_en" : (e_mis ? "R8 byte_en" : "R2 byte_en"), byte_en, e_be);
    if (st && !e_ill) check("R3 mem_wdata", mem_wdata, e_wd);
    check({ld_tag, " load_result"}, load_result, e_ld);
    check("R8 misaligned", misaligned, e_mis);
    check("R9 illegal", illegal, e_ill);
  endtask

  initial begin
    n_tests = 0; n_fail = 0;
    rst_n = 1'b0;
    op_is_store = 1'b0; size_code = 3'd0; base_addr = '0; offset = '0;
    store_data = '0; mem_rdata = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // idle inputs: byte load at address 0 of a zero word
    check("R1 reset mem_addr", mem_addr, 0);
    check("R2 reset byte_en", byte_en, 1);
    check("R4 reset load_result", load_result, 0);
    check("R9 reset illegal", illegal, 0);

    // every code, lane and direction with lane-distinct data
    for (int st = 0; st < 2; st++)
      for (int code = 0; code < 8; code++)
        for (int ln = 0; ln < 4; ln++)
          run_one(st[0], code, 32'h0000_1000 + ln, 12'h000, 32'hA1B2_C3D4, 32'h80FF_7F01);

    // sign fill versus zero fill on each lane
    for (int code = 0; code < 6; code++)
      for (int ln = 0; ln < 4; ln++)
        run_one(1'b0, code, 32'h0000_2000, ln[11:0], 32'h0, 32'h7F80_01FE);

    // negative displacement and carry across the word edge (R1)
    run_one(1'b0, 2, 32'h0000_1000, 12'hFFC, 32'h0, 32'hDEAD_BEEF);
    run_one(1'b0, 0, 32'h0000_1000, 12'hFFF, 32'h0, 32'h8000_0000);
    run_one(1'b1, 1, 32'h0000_0FFE, 12'h002, 32'h1234_ABCD, 32'h0);
    run_one(1'b1, 2, 32'hFFFF_FFFC, 12'h004, 32'h0102_0304, 32'h0);
    run_one(1'b0, 5, 32'h0000_0000, 12'h800, 32'h0, 32'hFFFF_8001);

    // pseudo-random sweep
    for (int k = 0; k < 3000; k++)
      run_one($urandom_range(1, 0) == 1, $urandom_range(7, 0), $urandom,
              12'($urandom), $urandom, $urandom);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule